// File: doc/BRIEF.md
# System-management interrupt request and acknowledge controller

This block sits next to a processor core and turns the active-low system-management interrupt pin into a request to the core's sequencer. It synchronises the pin and decides whether a request is taken. A taken request wins over any non-maskable interrupt request that is waiting at the same time. The controller then drives the active-low in-service indication, `smiact_n_o`, from the sequencer's acknowledge until the routine has finished. A routine finishes once the core has signalled resume and reported its last bus cycle to the protected memory window.

Two request semantics are available, picked by a configuration bit that takes effect only while the controller is idle. In the legacy semantics the pin is edge-triggered, and at most one extra edge is remembered while a routine is outstanding. In the enhanced semantics the pin is level-sensitive and routines may nest, with the depth tracked by a saturating counter. Caching of the protected window and nesting are offered to the surrounding logic as enable outputs, and these are only ever high in enhanced mode.

Top module: `smi_ctrl`

## Requirements
- R1: In legacy mode a request is taken only on a high-to-low transition of `smi_n_i` seen after two synchroniser flops; a pin held low raises no further request once its routine has completed.
- R2: `nmi_grant_o` follows `nmi_req_i` except while `smi_req_o` is high, when it is forced low.
- R3: `smiact_n_o` goes low on the clock edge where `seq_ack_i` is sampled high with `smi_req_o` high, and stays low for the whole routine.
- R4: After `seq_rsm_i`, `smiact_n_o` stays low until the edge where `seq_last_i` is sampled high, and it rises only then.
- R5: In legacy mode, one edge arriving while a request or routine is outstanding is remembered and requested again right after the resume completes; further edges in that interval are dropped.
- R6: Reset clears the SMI-use bit and the enhanced-mode bit; while the use bit is 0, no request is raised and `smiact_n_o` is held high.
- R7: A write with `cfg_wr_i` high loads `cfg_use_i` and `cfg_enh_i`; `cfg_enh_i` = 1 selects enhanced mode.
- R8: In enhanced mode a low pin raises a request, also inside a routine; each acknowledge increments a nesting depth that saturates at 3, and at depth 3 no request is raised.
- R9: In enhanced mode each completed resume decrements the depth, and `smiact_n_o` rises only when the depth returns to zero.
- R10: `smm_cache_en_o` and `smm_nest_en_o` are high only when the use bit is set and the effective mode is enhanced; they are 0 in legacy mode.
- R11: A change of the mode bit written while a routine is active takes effect only after the controller has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smi_n_i | input | 1 | Asynchronous active-low SMI request pin |
| nmi_req_i | input | 1 | Pending NMI request |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_use_i | input | 1 | SMI-use enable value to write |
| cfg_enh_i | input | 1 | Enhanced-mode select value to write |
| seq_ack_i | input | 1 | Sequencer acknowledge of the request |
| seq_rsm_i | input | 1 | Resume instruction executed |
| seq_last_i | input | 1 | Last bus cycle to the protected window completed |
| smi_req_o | output | 1 | Request to the sequencer |
| nmi_grant_o | output | 1 | NMI request passed on after arbitration |
| smiact_n_o | output | 1 | Active-low in-service indication, always driven |
| smm_cache_en_o | output | 1 | Caching of the protected window allowed |
| smm_nest_en_o | output | 1 | Nested entry allowed |

## Verification
On every cycle the assertions check the following: the arbitration never lets both requests out together, the in-service output falls only after an acknowledge and rises only after a last-cycle flag, it stays high while the use bit is clear, the enables are frozen during service, and the depth stays within bounds. Only the bench scenarios can show the rest. These are that an extra legacy edge is remembered once and the next one is dropped, that a held pin retriggers only in enhanced mode, that nesting saturates at three and unwinds one resume at a time, and that a mode write is deferred until idle.

// File: rtl/smi_ctrl_pkg.sv
// Shared types for the SMI controller.
package smi_ctrl_pkg;
    // Sequencer-facing state of the controller.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_SVC   = 2'd2,
        ST_DRAIN = 2'd3
    } smi_state_e;
endpackage

// File: rtl/smi_pin_sync.sv
// Synchroniser and detector for the SMI pin.
// Does: passes the asynchronous active-low pin through STAGES flops, then
// reports a falling transition and the current low level.
// Assumes: STAGES >= 2; the pin idles high, so the flops reset to 1.
module smi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic fall_o,
    output logic low_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], pin_n_i};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Edge and level outputs.
    always_comb begin
        fall_o = prev_q & ~sync_q[STAGES-1];
        low_o  = ~sync_q[STAGES-1];
    end
endmodule

// File: rtl/smi_cfg.sv
// Configuration bits of the SMI controller.
// Does: holds the SMI-use bit and the enhanced-mode bit, and copies the mode
// bit into the effective mode only while the sequencer reports idle.
// Assumes: idle_i is a registered state decode.
module smi_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic use_i,
    input  logic enh_i,
    input  logic idle_i,
    output logic use_o,
    output logic mode_act_o
);
    logic enh_q;

    // Configuration register; reset clears both bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_o <= 1'b0;
            enh_q <= 1'b0;
        end else if (wr_i) begin
            use_o <= use_i;
            enh_q <= enh_i;
        end
    end

    // Effective mode follows the written bit only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_act_o <= 1'b0;
        else if (idle_i) mode_act_o <= enh_q;
    end
endmodule

// File: rtl/smi_seq_fsm.sv
// Request and service sequencer for the SMI controller.
// Does: raises the request, tracks acknowledge, resume and the last protected
// bus cycle, keeps a one-deep pending edge in legacy mode and a saturating
// nesting depth in enhanced mode, and drives the in-service output.
// Assumes: the sequencer acknowledges only while the request is high and
// signals resume only while in service.
module smi_seq_fsm
    import smi_ctrl_pkg::*;
#(
    parameter int DEPTH_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               use_i,
    input  logic               enh_i,
    input  logic               fall_i,
    input  logic               low_i,
    input  logic               ack_i,
    input  logic               rsm_i,
    input  logic               last_i,
    output logic               req_o,
    output logic               smiact_n_o,
    output logic               idle_o,
    output logic [DEPTH_W-1:0] depth_o
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
    localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

    smi_state_e         st_q, st_n;
    logic [DEPTH_W-1:0] dp_q, dp_n;
    logic               pd_q, pd_n;

    // Request decode: initial entry, or nested entry in enhanced mode.
    always_comb begin
        req_o = (st_q == ST_REQ) ||
                (st_q == ST_SVC && enh_i && low_i && dp_q != DEPTH_MAX && !rsm_i);
    end

    // Next-state, depth and pending-edge logic.
    always_comb begin
        st_n = st_q;
        dp_n = dp_q;
        pd_n = pd_q;
        case (st_q)
            ST_IDLE: begin
                if (use_i && (enh_i ? low_i : (fall_i || pd_q))) begin
                    st_n = ST_REQ;
                    pd_n = 1'b0;
                end
            end
            ST_REQ: begin
                if (!use_i) begin
                    st_n = ST_IDLE;
                end else if (ack_i) begin
                    st_n = ST_SVC;
                    dp_n = dp_q + DEPTH_ONE;
                end
            end
            ST_SVC: begin
                if (rsm_i)             st_n = ST_DRAIN;
                else if (req_o && ack_i) dp_n = dp_q + DEPTH_ONE;
            end
            default: begin
                if (last_i) begin
                    dp_n = dp_q - DEPTH_ONE;
                    if (dp_q == DEPTH_ONE) begin
                        if (use_i && (enh_i ? low_i : pd_q)) begin
                            st_n = ST_REQ;
                            pd_n = 1'b0;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end else begin
                        st_n = ST_SVC;
                    end
                end
            end
        endcase
        if (!use_i || enh_i)
            pd_n = 1'b0;
        else if (fall_i && st_q != ST_IDLE)
            pd_n = 1'b1;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            dp_q <= '0;
            pd_q <= 1'b0;
        end else begin
            st_q <= st_n;
            dp_q <= dp_n;
            pd_q <= pd_n;
        end
    end

    // Outputs decoded from registered state.
    always_comb begin
        smiact_n_o = !(use_i && (st_q == ST_SVC || st_q == ST_DRAIN));
        idle_o     = (st_q == ST_IDLE);
        depth_o    = dp_q;
    end
endmodule

// File: rtl/smi_ctrl.sv
// SMI request and acknowledge controller, top level.
// Does: joins the pin synchroniser, configuration bits and sequencer, and
// arbitrates NMI behind SMI.
// Assumes: all inputs except smi_n_i are synchronous to clk.
module smi_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int DEPTH_W     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smi_n_i,
    input  logic nmi_req_i,
    input  logic cfg_wr_i,
    input  logic cfg_use_i,
    input  logic cfg_enh_i,
    input  logic seq_ack_i,
    input  logic seq_rsm_i,
    input  logic seq_last_i,
    output logic smi_req_o,
    output logic nmi_grant_o,
    output logic smiact_n_o,
    output logic smm_cache_en_o,
    output logic smm_nest_en_o
);
    logic               pin_fall, pin_low;
    logic               use_q, mode_act, idle;
    logic [DEPTH_W-1:0] depth;

    smi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n_i(smi_n_i),
        .fall_o(pin_fall), .low_o(pin_low)
    );

    smi_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .use_i(cfg_use_i),
        .enh_i(cfg_enh_i), .idle_i(idle), .use_o(use_q), .mode_act_o(mode_act)
    );

    smi_seq_fsm #(.DEPTH_W(DEPTH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .use_i(use_q), .enh_i(mode_act),
        .fall_i(pin_fall), .low_i(pin_low), .ack_i(seq_ack_i),
        .rsm_i(seq_rsm_i), .last_i(seq_last_i), .req_o(smi_req_o),
        .smiact_n_o(smiact_n_o), .idle_o(idle), .depth_o(depth)
    );

    // NMI waits behind a raised SMI request; mode-qualified enables.
    always_comb begin
        nmi_grant_o    = nmi_req_i && !smi_req_o;
        smm_cache_en_o = use_q && mode_act;
        smm_nest_en_o  = use_q && mode_act;
    end
endmodule

// File: rtl/smi_ctrl_chk.sv
// Checker for smi_ctrl, bound to every instance.
// Does: watches ports and configuration state for protocol violations.
module smi_ctrl_chk #(
    parameter int DEPTH_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smi_req_o,
    input logic               nmi_grant_o,
    input logic               smiact_n_o,
    input logic               smm_cache_en_o,
    input logic               seq_ack_i,
    input logic               seq_last_i,
    input logic               use_q,
    input logic               mode_act,
    input logic [DEPTH_W-1:0] depth
);
    // R2
    nmi_behind_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(smi_req_o && nmi_grant_o));

    // R3
    act_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smiact_n_o) |-> $past(seq_ack_i));

    // R4
    release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_q && $past(use_q) && $rose(smiact_n_o)) |-> $past(seq_last_i));

    // R6
    unused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !use_q |-> smiact_n_o);

    // R11
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smiact_n_o && $past(!smiact_n_o)) |-> $stable(smm_cache_en_o));

    // R5
    legacy_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_act |-> (depth <= DEPTH_W'(1)));

    // R8
    depth_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '1) |=> (depth != '0));
endmodule

bind smi_ctrl smi_ctrl_chk #(.DEPTH_W(DEPTH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smi_req_o(smi_req_o), .nmi_grant_o(nmi_grant_o),
    .smiact_n_o(smiact_n_o), .smm_cache_en_o(smm_cache_en_o),
    .seq_ack_i(seq_ack_i), .seq_last_i(seq_last_i), .use_q(use_q),
    .mode_act(mode_act), .depth(depth)
);

// File: tb/smi_ctrl_tb.sv
// Self-checking bench for smi_ctrl.
module smi_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smi_n = 1'b1, nmi = 1'b0, cfg_wr = 1'b0, cfg_use = 1'b0, cfg_enh = 1'b0;
    logic ack = 1'b0, rsm = 1'b0, last = 1'b0;
    logic smi_req, nmi_grant, smiact_n, cache_en, nest_en;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    smi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .smi_n_i(smi_n), .nmi_req_i(nmi),
        .cfg_wr_i(cfg_wr), .cfg_use_i(cfg_use), .cfg_enh_i(cfg_enh),
        .seq_ack_i(ack), .seq_rsm_i(rsm), .seq_last_i(last),
        .smi_req_o(smi_req), .nmi_grant_o(nmi_grant), .smiact_n_o(smiact_n),
        .smm_cache_en_o(cache_en), .smm_nest_en_o(nest_en)
    );

    // {req id, smi_n, nmi, ack, rsm, last, exp smi_req, exp nmi_grant, exp smiact_n}
    // Legacy walk: edge, arbitration, service, one remembered edge, one dropped.
    localparam logic [11:0] VEC [19] = '{
        {4'd1, 5'b00000, 3'b001},  // R1 pin falls, still in synchroniser
        {4'd2, 5'b01000, 3'b011},  // R2 NMI passes before SMI request
        {4'd2, 5'b01000, 3'b101},  // R2 SMI request blocks NMI
        {4'd3, 5'b00100, 3'b000},  // R3 acknowledge enters service
        {4'd3, 5'b10000, 3'b000},
        {4'd3, 5'b10000, 3'b000},
        {4'd3, 5'b00000, 3'b000},  // second edge during service
        {4'd3, 5'b00000, 3'b000},
        {4'd5, 5'b10000, 3'b000},
        {4'd5, 5'b10000, 3'b000},
        {4'd5, 5'b00000, 3'b000},  // R5 third edge, dropped
        {4'd5, 5'b00000, 3'b000},
        {4'd4, 5'b00010, 3'b000},  // R4 resume
        {4'd4, 5'b00000, 3'b000},  // R4 still active before last cycle
        {4'd5, 5'b00001, 3'b101},  // R5 remembered edge requested again
        {4'd3, 5'b00100, 3'b000},
        {4'd4, 5'b00010, 3'b000},
        {4'd5, 5'b00001, 3'b001},  // R5 dropped edge not serviced
        {4'd1, 5'b00000, 3'b001}   // R1 held low pin does not retrigger
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic u, input logic e);
        cfg_wr = 1'b1; cfg_use = u; cfg_enh = e;
        step();
        cfg_wr = 1'b0;
        step();
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic resume_one();
        rsm = 1'b1; step(); rsm = 1'b0;
        last = 1'b1; step(); last = 1'b0;
    endtask

    task automatic wait_req(input string req);
        bit seen = 1'b0;
        for (int k = 0; k < 10 && !seen; k++) begin
            if (smi_req) seen = 1'b1;
            else step();
        end
        check(req, seen, 1'b1);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R6 reset state
        check("R6", smiact_n, 1'b1);
        check("R6", smi_req, 1'b0);
        check("R10", cache_en, 1'b0);
        // R6 falling pin ignored while the use bit is clear
        smi_n = 1'b0;
        repeat (5) step();
        check("R6", smi_req, 1'b0);
        check("R6", smiact_n, 1'b1);
        // R7 enable legacy use; pin already low so no edge
        cfg_write(1'b1, 1'b0);
        check("R1", smi_req, 1'b0);
        check("R10", nest_en, 1'b0);
        smi_n = 1'b1;
        repeat (4) step();

        // Vector walk
        for (int i = 0; i < 19; i++) begin
            {smi_n, nmi, ack, rsm, last} = VEC[i][7:3];
            step();
            n_chk++;
            if ({smi_req, nmi_grant, smiact_n} !== VEC[i][2:0]) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: got %b expected %b", VEC[i][11:8], i,
                         {smi_req, nmi_grant, smiact_n}, VEC[i][2:0]);
            end
        end
        {smi_n, nmi, ack, rsm, last} = 5'b10000;
        repeat (4) step();

        // R7 switch to enhanced mode while idle
        cfg_write(1'b1, 1'b1);
        check("R10", cache_en, 1'b1);
        check("R10", nest_en, 1'b1);
        // R8 level request and nesting
        smi_n = 1'b0;
        wait_req("R8");
        pulse_ack();
        check("R3", smiact_n, 1'b0);
        check("R8", smi_req, 1'b1);
        pulse_ack();
        check("R8", smi_req, 1'b1);
        pulse_ack();
        check("R8", smi_req, 1'b0);
        smi_n = 1'b1;
        repeat (4) step();
        // R9 unwind one level at a time
        resume_one();
        check("R9", smiact_n, 1'b0);
        resume_one();
        check("R9", smiact_n, 1'b0);
        resume_one();
        check("R9", smiact_n, 1'b1);
        check("R9", smi_req, 1'b0);

        // R11 mode write deferred during service
        smi_n = 1'b0;
        wait_req("R8");
        pulse_ack();
        smi_n = 1'b1;
        cfg_write(1'b1, 1'b0);
        check("R11", cache_en, 1'b1);
        repeat (3) step();
        resume_one();
        check("R11", smiact_n, 1'b1);
        step();
        check("R10", cache_en, 1'b0);
        check("R10", nest_en, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule